// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides, sample by sample, when a logic analyzer stores data and when its trigger fires. It walks a programmable chain of up to sixteen steps. For every step, separate term evaluators outside the block supply three boolean results, one bit per step: a hit term, an else term and a capture term. The sequencer uses only the three bits of the step it currently occupies.

Each step has its own table entry. The entry holds an occurrence threshold, a successor for the hit path, a target for the else path, and a flag that marks the step as the final one. Hits are accumulated over all valid samples spent in a step, so they do not need to be contiguous. An else transition throws the accumulated count away. A recognised hit in the final step fires the trigger. The trigger then stays fired, and every valid sample is stored, until an arm pulse restarts the chain at step 0. The block ignores cycles without a valid sample, so it behaves the same whether samples arrive on an internal or an external clock.

Top module: `trig_sequencer`

## Requirements
- R1: After reset the block is in step 0 with a zero occurrence count and `fired` low. Every table entry reads as threshold 0, hit successor 0, else target 0 and not final.
- R2: While `fired` is low, `capture` equals `sample_valid & cap_terms[s]` in the same cycle, where s is the current step and bit i of each term vector belongs to step i.
- R3: The hit-term samples spent in a step are counted cumulatively, and valid samples without a hit do not clear the count. A hit is recognised on the hit-term sample that brings the count to the step's threshold. A threshold of 0 behaves like a threshold of 1.
- R4: A recognised hit in a non-final step moves the sequencer to that step's hit successor from the next cycle on, and the new step's count starts at zero.
- R5: A valid sample whose current-step hit term is low and whose else term is high moves the sequencer to the else target and clears the count. The else target may be the current step.
- R6: When the hit and else terms of the current step are both high in one sample, the else term is ignored and the sample is handled as a hit sample.
- R7: A cycle with `sample_valid` low changes neither the step, nor the count, nor `fired`.
- R8: A recognised hit in a step flagged final raises `fired` from the next cycle on. `fired` then stays high and the step no longer changes, whatever the terms do, until an arm pulse.
- R9: While `fired` is high, `capture` equals `sample_valid`, whatever the capture terms are.
- R10: `arm` high at a clock edge returns the block to step 0 with a zero count and `fired` low, and leaves the table unchanged. It overrides any sample in the same cycle.
- R11: A table write with `cfg_we` high replaces the whole entry at `cfg_idx` only. A sample in the same cycle is evaluated against the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Synchronous restart of the sequence |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | SW | Step whose entry is written |
| cfg_occ | input | CNT_W | Occurrence threshold to write |
| cfg_hit_tgt | input | SW | Hit-path successor to write |
| cfg_else_tgt | input | SW | Else-path target to write |
| cfg_final | input | 1 | Final-step flag to write |
| sample_valid | input | 1 | A sample is present this cycle |
| hit_terms | input | NUM_STATES | Hit term result, one bit per step |
| else_terms | input | NUM_STATES | Else term result, one bit per step |
| cap_terms | input | NUM_STATES | Capture term result, one bit per step |
| capture | output | 1 | Store the current sample |
| fired | output | 1 | The trigger has fired |

## Verification
Two functions can fall on the same sample: the hit path and the else path, when both terms of the current step are high. A table write or an arm pulse can also coincide with a valid sample. The directed part of the bench raises both terms together in a step with threshold 0 and checks that the step reached is the hit successor. It also does this with a higher threshold and checks that the count keeps growing. It writes an entry and arms in the same cycles as live samples. A random phase then creates many more such coincidences, and a behavioural model decides every cycle whether `capture` and `fired` are right.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

   // Action taken by the sequencer at the next clock edge.
   typedef enum logic [2:0] {
      ACT_IDLE    = 3'd0,   // no valid sample, or already fired
      ACT_COUNT   = 3'd1,   // hit term seen, threshold not yet reached
      ACT_ADVANCE = 3'd2,   // hit recognised, go to successor
      ACT_ELSE    = 3'd3,   // else path taken
      ACT_FIRE    = 3'd4,   // hit recognised in final step
      ACT_ARM     = 3'd5    // restart
   } seq_act_t;

endpackage

// File: rtl/trig_seq_table.sv
module trig_seq_table #(
   parameter int NUM_STATES = 16,
   parameter int CNT_W      = 20,
   parameter int SW         = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SW-1:0]    wr_idx,
   input  logic [CNT_W-1:0] wr_occ,
   input  logic [SW-1:0]    wr_hit_tgt,
   input  logic [SW-1:0]    wr_else_tgt,
   input  logic             wr_final,
   input  logic [SW-1:0]    rd_idx,
   output logic [CNT_W-1:0] rd_occ,
   output logic [SW-1:0]    rd_hit_tgt,
   output logic [SW-1:0]    rd_else_tgt,
   output logic             rd_final
);

   logic [CNT_W-1:0] occ_q      [NUM_STATES];
   logic [SW-1:0]    hit_tgt_q  [NUM_STATES];
   logic [SW-1:0]    else_tgt_q [NUM_STATES];
   logic             final_q    [NUM_STATES];

   for (genvar g = 0; g < NUM_STATES; g++) begin : g_entry
      logic sel;
      assign sel = we && (wr_idx == SW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_q[g]      <= '0;
            hit_tgt_q[g]  <= '0;
            else_tgt_q[g] <= '0;
            final_q[g]    <= 1'b0;
         end else if (sel) begin
            occ_q[g]      <= wr_occ;
            hit_tgt_q[g]  <= wr_hit_tgt;
            else_tgt_q[g] <= wr_else_tgt;
            final_q[g]    <= wr_final;
         end
      end
   end

   assign rd_occ      = occ_q[rd_idx];
   assign rd_hit_tgt  = hit_tgt_q[rd_idx];
   assign rd_else_tgt = else_tgt_q[rd_idx];
   assign rd_final    = final_q[rd_idx];

endmodule

// File: rtl/trig_seq_occ.sv
module trig_seq_occ #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] thresh,
   output logic [CNT_W-1:0] cnt,
   output logic             reached
);

   localparam int EW = CNT_W + 1;

   logic [EW-1:0] eff_thresh;
   logic [EW-1:0] next_cnt;

   // A threshold of zero is treated as one.
   assign eff_thresh = (thresh == '0) ? EW'(1) : {1'b0, thresh};
   assign next_cnt   = {1'b0, cnt} + EW'(1);
   assign reached    = (next_cnt >= eff_thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= next_cnt[CNT_W-1:0];
   end

endmodule

// File: rtl/trig_seq_decide.sv
module trig_seq_decide
   import trig_seq_pkg::*;
(
   input  logic     arm,
   input  logic     valid,
   input  logic     fired,
   input  logic     hit_bit,
   input  logic     else_bit,
   input  logic     reached,
   input  logic     is_final,
   output seq_act_t act
);

   always_comb begin
      act = ACT_IDLE;
      if (arm) begin
         act = ACT_ARM;
      end else if (valid && !fired) begin
         if (hit_bit) begin
            if (!reached)     act = ACT_COUNT;
            else if (is_final) act = ACT_FIRE;
            else              act = ACT_ADVANCE;
         end else if (else_bit) begin
            act = ACT_ELSE;
         end
      end
   end

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
   import trig_seq_pkg::*;
#(
   parameter  int NUM_STATES = 16,
   parameter  int CNT_W      = 20,
   localparam int SW         = $clog2(NUM_STATES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arm,
   input  logic                  cfg_we,
   input  logic [SW-1:0]         cfg_idx,
   input  logic [CNT_W-1:0]      cfg_occ,
   input  logic [SW-1:0]         cfg_hit_tgt,
   input  logic [SW-1:0]         cfg_else_tgt,
   input  logic                  cfg_final,
   input  logic                  sample_valid,
   input  logic [NUM_STATES-1:0] hit_terms,
   input  logic [NUM_STATES-1:0] else_terms,
   input  logic [NUM_STATES-1:0] cap_terms,
   output logic                  capture,
   output logic                  fired
);

   initial begin
      assert (NUM_STATES >= 2 && (1 << SW) == NUM_STATES)
         else $error("NUM_STATES must be a power of two, at least 2");
      assert (CNT_W >= 1 && CNT_W <= 31)
         else $error("CNT_W must be between 1 and 31");
   end

   logic [SW-1:0]    cur_state;
   logic [CNT_W-1:0] occ_cnt;
   logic             occ_reached;
   logic [CNT_W-1:0] ent_occ;
   logic [SW-1:0]    ent_hit_tgt;
   logic [SW-1:0]    ent_else_tgt;
   logic             ent_final;
   seq_act_t         act;
   logic             occ_clr;
   logic             occ_inc;

   trig_seq_table #(
      .NUM_STATES (NUM_STATES),
      .CNT_W      (CNT_W),
      .SW         (SW)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (cfg_we),
      .wr_idx      (cfg_idx),
      .wr_occ      (cfg_occ),
      .wr_hit_tgt  (cfg_hit_tgt),
      .wr_else_tgt (cfg_else_tgt),
      .wr_final    (cfg_final),
      .rd_idx      (cur_state),
      .rd_occ      (ent_occ),
      .rd_hit_tgt  (ent_hit_tgt),
      .rd_else_tgt (ent_else_tgt),
      .rd_final    (ent_final)
   );

   assign occ_clr = (act == ACT_ARM) || (act == ACT_ADVANCE) || (act == ACT_ELSE);
   assign occ_inc = (act == ACT_COUNT);

   trig_seq_occ #(
      .CNT_W (CNT_W)
   ) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (occ_clr),
      .inc     (occ_inc),
      .thresh  (ent_occ),
      .cnt     (occ_cnt),
      .reached (occ_reached)
   );

   trig_seq_decide u_decide (
      .arm      (arm),
      .valid    (sample_valid),
      .fired    (fired),
      .hit_bit  (hit_terms[cur_state]),
      .else_bit (else_terms[cur_state]),
      .reached  (occ_reached),
      .is_final (ent_final),
      .act      (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_state <= '0;
         fired     <= 1'b0;
      end else begin
         case (act)
            ACT_ARM: begin
               cur_state <= '0;
               fired     <= 1'b0;
            end
            ACT_ADVANCE: cur_state <= ent_hit_tgt;
            ACT_ELSE:    cur_state <= ent_else_tgt;
            ACT_FIRE:    fired     <= 1'b1;
            default: ;
         endcase
      end
   end

   assign capture = sample_valid && (fired || cap_terms[cur_state]);

endmodule

// File: rtl/trig_sequencer_chk.sv
module trig_sequencer_chk #(
   parameter int NUM_STATES = 16,
   parameter int CNT_W      = 20,
   parameter int SW         = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  arm,
   input logic                  sample_valid,
   input logic [NUM_STATES-1:0] hit_terms,
   input logic [NUM_STATES-1:0] else_terms,
   input logic                  capture,
   input logic                  fired,
   input logic [SW-1:0]         cur_state,
   input logic [CNT_W-1:0]      occ_cnt
);

   assert_no_cap_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> !capture);

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid && !arm) |=> ($stable(cur_state) && $stable(occ_cnt) && $stable(fired)));

   assert_fired_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fired && !arm) |=> fired);

   assert_frozen_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fired && !arm) |=> $stable(cur_state));

   assert_arm_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!fired && cur_state == '0 && occ_cnt == '0));

   assert_else_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && !arm && !fired && !hit_terms[cur_state] && else_terms[cur_state])
      |=> (occ_cnt == '0));

endmodule

bind trig_sequencer trig_sequencer_chk #(
   .NUM_STATES (NUM_STATES),
   .CNT_W      (CNT_W),
   .SW         (SW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm          (arm),
   .sample_valid (sample_valid),
   .hit_terms    (hit_terms),
   .else_terms   (else_terms),
   .capture      (capture),
   .fired        (fired),
   .cur_state    (cur_state),
   .occ_cnt      (occ_cnt)
);

// File: tb/test_trig_sequencer.sv
`timescale 1ns/1ps
module test_trig_sequencer;

   localparam int NS = 16;
   localparam int CW = 20;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic          cfg_we = 1'b0;
   logic [SW-1:0] cfg_idx = '0;
   logic [CW-1:0] cfg_occ = '0;
   logic [SW-1:0] cfg_hit_tgt = '0;
   logic [SW-1:0] cfg_else_tgt = '0;
   logic          cfg_final = 1'b0;
   logic          sample_valid = 1'b0;
   logic [NS-1:0] hit_terms = '0;
   logic [NS-1:0] else_terms = '0;
   logic [NS-1:0] cap_terms = '0;
   logic          capture;
   logic          fired;

   always #10 clk = ~clk;   // 50 MHz

   trig_sequencer #(.NUM_STATES(NS), .CNT_W(CW)) i_trig_sequencer (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_occ(cfg_occ),
      .cfg_hit_tgt(cfg_hit_tgt), .cfg_else_tgt(cfg_else_tgt), .cfg_final(cfg_final),
      .sample_valid(sample_valid), .hit_terms(hit_terms), .else_terms(else_terms),
      .cap_terms(cap_terms), .capture(capture), .fired(fired)
   );

   // Behavioural reference model
   int m_state, m_cnt;
   bit m_fired;
   int t_occ[NS], t_hit[NS], t_else[NS];
   bit t_fin[NS];

   int  n_checks = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   task automatic check(string tag, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge(bit v, logic [NS-1:0] h, logic [NS-1:0] e, bit a);
      int thr;
      if (a) begin
         m_state = 0; m_cnt = 0; m_fired = 0;
      end else if (v && !m_fired) begin
         if (h[m_state]) begin
            thr = (t_occ[m_state] == 0) ? 1 : t_occ[m_state];
            if (m_cnt + 1 >= thr) begin
               if (t_fin[m_state]) m_fired = 1;
               else begin m_state = t_hit[m_state]; m_cnt = 0; end
            end else m_cnt++;
         end else if (e[m_state]) begin
            m_state = t_else[m_state]; m_cnt = 0;
         end
      end
   endtask

   // One clock cycle: drive, compare outputs, advance the model.
   task automatic step(string tag, bit v, logic [NS-1:0] h, logic [NS-1:0] e,
                       logic [NS-1:0] c, bit a);
      @(negedge clk);
      cfg_we = 1'b0; sample_valid = v; hit_terms = h; else_terms = e;
      cap_terms = c; arm = a;
      #2;
      check(tag, "capture", capture, v && (m_fired || c[m_state]));
      check(tag, "fired", fired, m_fired);
      model_edge(v, h, e, a);
   endtask

   // Table write, optionally together with a live sample.
   task automatic wcfg(string tag, int idx, int occ, int ht, int et, bit fin,
                       bit v, logic [NS-1:0] h, logic [NS-1:0] e);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = SW'(idx); cfg_occ = CW'(occ);
      cfg_hit_tgt = SW'(ht); cfg_else_tgt = SW'(et); cfg_final = fin;
      sample_valid = v; hit_terms = h; else_terms = e; cap_terms = '0; arm = 1'b0;
      #2;
      check(tag, "fired", fired, m_fired);
      model_edge(v, h, e, 1'b0);   // sample uses the old entry
      t_occ[idx] = occ; t_hit[idx] = ht; t_else[idx] = et; t_fin[idx] = fin;
   endtask

   function automatic logic [NS-1:0] oh(int i);
      return NS'(1) << i;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin : main
      m_state = 0; m_cnt = 0; m_fired = 0;
      for (int i = 0; i < NS; i++) begin
         t_occ[i] = 0; t_hit[i] = 0; t_else[i] = 0; t_fin[i] = 0;
      end
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;

      // R1: reset state and zeroed table
      step("R1", 1, '0, '0, oh(0), 0);
      step("R1", 1, '1, '0, oh(0), 0);     // zero entry: hit goes back to step 0
      step("R1", 1, '0, '0, oh(0), 0);
      step("R1", 1, '1, '0, '1, 0);        // not final: no fire

      // Program table
      wcfg("R11", 0, 3, 1, 2, 0, 0, '0, '0);
      wcfg("R11", 1, 0, 3, 1, 0, 0, '0, '0);
      wcfg("R11", 2, 1, 0, 2, 0, 0, '0, '0);
      wcfg("R11", 3, 2, 0, 0, 1, 0, '0, '0);

      // R2: capture term selection by current step
      step("R2", 1, '0, '0, ~oh(0), 0);
      step("R2", 0, '0, '0, oh(0), 0);
      step("R2", 1, '0, '0, oh(0), 0);

      // R3: cumulative hits with gaps, threshold 3
      step("R3", 1, oh(0), '0, oh(0), 0);
      step("R3", 1, '0, '0, oh(0), 0);
      step("R3", 1, oh(0), '0, oh(0), 0);
      step("R3", 1, '0, '0, oh(0), 0);
      step("R3", 1, oh(0), '0, oh(0), 0);  // third hit
      // R4: now in step 1
      step("R4", 1, '0, '0, oh(1), 0);
      // R6: hit and else together in step 1 (threshold 0): hit wins, to step 3
      step("R6", 1, oh(1), oh(1), oh(1), 0);
      step("R6", 1, '0, '0, oh(3), 0);
      // R5: one hit in step 3 then else to step 0, count must be cleared
      step("R5", 1, oh(3), '0, oh(3), 0);
      step("R5", 1, '0, oh(3), oh(3), 0);
      step("R5", 1, '0, '0, oh(0), 0);
      for (int k = 0; k < 3; k++) step("R5", 1, oh(0), '0, oh(0), 0);
      step("R5", 1, oh(1), '0, oh(1), 0);
      step("R5", 1, oh(3), '0, oh(3), 0);  // first hit only
      // R7: no valid sample: hits ignored
      step("R7", 0, '1, '1, oh(3), 0);
      step("R7", 0, '1, '0, oh(3), 0);
      step("R7", 1, '0, '0, oh(3), 0);     // still step 3, not fired
      // R8: second hit fires
      step("R8", 1, oh(3), '0, oh(3), 0);
      step("R8", 1, '1, '1, '0, 0);
      step("R9", 1, '0, '0, '0, 0);
      step("R9", 0, '0, '0, '1, 0);
      step("R8", 1, '0, '1, '0, 0);
      // R10: arm with a sample in the same cycle
      step("R10", 1, '1, '1, '0, 1);
      step("R10", 1, '0, '0, oh(0), 0);
      step("R10", 1, oh(0), '0, oh(0), 0); // threshold 3 kept: count 1
      step("R10", 1, '0, '0, oh(0), 0);
      // R6 with threshold not reached: hit counting beats else
      step("R6", 1, oh(0), oh(0), oh(0), 0);
      step("R6", 1, '0, '0, oh(0), 0);
      step("R6", 1, oh(0), '0, oh(0), 0);  // third hit -> step 1
      step("R6", 1, '0, '0, oh(1), 0);
      // R11: write during a sample uses old entry; other entries untouched
      step("R11", 1, '0, '0, '0, 1);
      wcfg("R11", 0, 1, 2, 0, 0, 1, oh(0), '0);  // old threshold 3: count only
      step("R11", 1, '0, '0, oh(0), 0);
      step("R11", 1, oh(0), '0, oh(0), 0);       // new threshold 1 (count>=1)
      step("R11", 1, '0, '0, oh(2), 0);
      // R5: else to self in step 2
      step("R5", 1, '0, oh(2), oh(2), 0);
      step("R5", 1, '0, '0, oh(2), 0);
      step("R3", 1, oh(2), '0, oh(2), 0);        // threshold 1 -> step 0
      step("R3", 1, '0, '0, oh(0), 0);

      // Random phase against the model
      for (int n = 0; n < 6000; n++) begin
         if (($urandom % 40) == 0)
            wcfg("R11", $urandom % NS, $urandom % 4, $urandom % NS, $urandom % NS,
                 (($urandom % 3) == 0), $urandom % 2, NS'($urandom), NS'($urandom & $urandom));
         else
            step("R3", ($urandom % 4) != 0, NS'($urandom), NS'($urandom & $urandom),
                 NS'($urandom), ($urandom % 150) == 0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule